// File: doc/BRIEF.md
# Four-Lane Swizzle Permute Unit

This block rearranges the lanes of a four-element sub-vector. An 8-bit selector holds four 2-bit fields. Each field names the source lane that feeds one output lane. The data is picked whole by lane, with no arithmetic, so integer and floating-point elements travel through the same wiring.

A second mode takes two source vectors. The two low output lanes are picked from the first source and the two high output lanes from the second. This covers interleave and shuffle patterns such as the steps of a 4x4 matrix transpose.

Permutation applies only while the sub-vector enable is high. When the sub-vector length is zero the enable is low, and the first source goes straight through. The result is registered, so it appears one cycle after the input and carries a matching valid.

Top module: `swz4_permute`

## Requirements
- R1: While reset (`rst_n` low) is asserted, `out_valid` is 0 and `out_vec` is all zeros.
- R2: `out_valid` equals `in_valid` from the previous clock edge, which gives one cycle of latency.
- R3: In single-source mode (`sub_en`=1, `two_src`=0), output lane k is the lane of `src_a` selected by `sel[2k+1:2k]`. Lane k occupies bits `[k*EW +: EW]`. `sel[1:0]` drives lane x (0), `sel[3:2]` drives y (1), `sel[5:4]` drives z (2) and `sel[7:6]` drives w (3).
- R4: With `sel` = 8'hE4 in single-source mode, the output equals `src_a`.
- R5: When all four selector fields hold the same index i in single-source mode, lane i of `src_a` appears on all four output lanes.
- R6: In two-source mode (`sub_en`=1, `two_src`=1), output lanes 0 and 1 take `src_a` lanes chosen by fields 0 and 1. Output lanes 2 and 3 take `src_b` lanes chosen by fields 2 and 3.
- R7: With `sub_en`=0, the output equals `src_a` unpermuted. `sel` and `two_src` have no effect.
- R8: `fp_mode` (0 = integer, 1 = floating point) does not change the result.
- R9: While `in_valid` is 0, `out_vec` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vectors and controls are valid |
| sub_en | input | 1 | Sub-vector length is nonzero; enables permutation |
| two_src | input | 1 | 1 selects the two-source lo/hi shuffle |
| fp_mode | input | 1 | Element kind tag: 0 integer, 1 floating point |
| sel | input | 8 | Four 2-bit lane selectors, lane x in the low bits |
| src_a | input | 4*EW | First source vector, lane 0 in the low bits |
| src_b | input | 4*EW | Second source vector (two-source mode only) |
| out_vec | output | 4*EW | Registered permuted vector |
| out_valid | output | 1 | Registered valid, one cycle after in_valid |

## Verification
Two functions can act in the same cycle. One is selector decoding. The other is bypass when the sub-vector enable is low, or the lo/hi source split when two-source mode is set. The bench applies one selector value, 8'h1B, under three conditions: single-source mode, two-source mode, and with the enable low. Each expected vector is written by hand from the lane rules. In the bypass cases the output must match `src_a` exactly, so any leakage of the selector into the result shows up.

// File: rtl/swz4_permute.sv
module swz4_permute #(
  parameter int EW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            sub_en,
  input  logic            two_src,
  input  logic            fp_mode,
  input  logic [7:0]      sel,
  input  logic [4*EW-1:0] src_a,
  input  logic [4*EW-1:0] src_b,
  output logic [4*EW-1:0] out_vec,
  output logic            out_valid
);
  localparam int VW = 4 * EW;

  logic [EW-1:0] a_l [4];
  logic [EW-1:0] b_l [4];
  logic [VW-1:0] nxt;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [1:0] idx;
    assign a_l[k] = src_a[k*EW +: EW];
    assign b_l[k] = src_b[k*EW +: EW];
    assign idx    = sel[2*k +: 2];
    if (k >= 2) begin : g_hi
      assign nxt[k*EW +: EW] = !sub_en ? a_l[k] : (two_src ? b_l[idx] : a_l[idx]);
    end else begin : g_lo
      assign nxt[k*EW +: EW] = !sub_en ? a_l[k] : a_l[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vec   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_vec <= nxt;
    end
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_vec));
  // R7
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sub_en) |=> (out_vec == $past(src_a)));
  // R4 R8
  ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sub_en && !two_src && sel == 8'hE4 && (fp_mode || !fp_mode))
      |=> (out_vec == $past(src_a)));
  // R5
  bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sub_en && !two_src && sel[1:0] == sel[3:2] &&
     sel[3:2] == sel[5:4] && sel[5:4] == sel[7:6])
      |=> (out_vec[0 +: EW] == out_vec[EW +: EW] &&
           out_vec[EW +: EW] == out_vec[2*EW +: EW] &&
           out_vec[2*EW +: EW] == out_vec[3*EW +: EW]));
endmodule

// File: tb/swz4_permute_tb.sv
module swz4_permute_tb;
  localparam int CLK_PERIOD = 10;
  localparam int EW = 8;
  localparam logic [31:0] VA = 32'h44332211;
  localparam logic [31:0] VB = 32'hDDCCBBAA;
  // entry: {req, sub_en, two_src, fp_mode, sel, expected}
  localparam int NV = 11;
  localparam logic [46:0] TBL [NV] = '{
    {4'd4, 3'b100, 8'hE4, 32'h44332211},  // R4 identity
    {4'd8, 3'b101, 8'hE4, 32'h44332211},  // R8 fp identity
    {4'd3, 3'b100, 8'h1B, 32'h11223344},  // R3 reverse
    {4'd8, 3'b101, 8'h1B, 32'h11223344},  // R8 fp reverse
    {4'd5, 3'b100, 8'hAA, 32'h33333333},  // R5 broadcast lane 2
    {4'd5, 3'b100, 8'h00, 32'h11111111},  // R5 broadcast lane 0
    {4'd6, 3'b110, 8'hE4, 32'hDDCC2211},  // R6 lo A, hi B
    {4'd6, 3'b110, 8'h1B, 32'hAABB3344},  // R6 crossed
    {4'd7, 3'b000, 8'h1B, 32'h44332211},  // R7 bypass
    {4'd7, 3'b010, 8'h1B, 32'h44332211},  // R7 bypass, two_src ignored
    {4'd3, 3'b100, 8'h8D, 32'h33114422}   // R3 mixed
  };

  logic clk = 0, rst_n = 0, in_valid = 0, sub_en = 0, two_src = 0, fp_mode = 0;
  logic [7:0] sel = '0;
  logic [4*EW-1:0] src_a = '0, src_b = '0, out_vec;
  logic out_valid;
  int errs = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swz4_permute #(.EW(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_en(sub_en),
    .two_src(two_src), .fp_mode(fp_mode), .sel(sel), .src_a(src_a),
    .src_b(src_b), .out_vec(out_vec), .out_valid(out_valid));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {31'd0, out_valid}, 32'd0);
    chk("R1", out_vec, 32'd0);
    rst_n = 1;
    src_a = VA; src_b = VB;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {sub_en, two_src, fp_mode} = TBL[i][42:40];
      sel = TBL[i][39:32];
      in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      chk("R2", {31'd0, out_valid}, 32'd1);
      chk($sformatf("R%0d", TBL[i][46:43]), out_vec, TBL[i][31:0]);
    end
    // R9: inputs change while idle; output holds, valid drops
    @(negedge clk);
    sel = 8'h1B; sub_en = 1; two_src = 0; src_a = 32'h01020304;
    @(negedge clk);
    chk("R2", {31'd0, out_valid}, 32'd0);
    chk("R9", out_vec, 32'h33114422);
    // R7 with changed data
    in_valid = 1; sub_en = 0;
    @(negedge clk);
    in_valid = 0;
    chk("R7", out_vec, 32'h01020304);
    // R1 reset clears output
    rst_n = 0;
    @(negedge clk);
    chk("R1", out_vec, 32'd0);
    chk("R1", {31'd0, out_valid}, 32'd0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule